// File: doc/BRIEF.md
# Ticket Lock Arbiter

This block is a hardware ticket lock shared by a fixed set of requesters. It holds two wrapping counters: an issue counter that records how many tickets have been handed out, and a serving counter that records how many releases have completed. A requester wanting the lock raises its request line. When the request is accepted, the requester receives the current issue count as its ticket and the issue counter advances by one in the same step. That step is an atomic fetch-and-increment, not a test-and-set.

The serving count is broadcast to all requesters. A requester owns the lock while the broadcast value equals its ticket. The owner pulses the release input when it is done, and the serving count advances by one. Because tickets are consumed strictly in issue order, the lock passes in first-come first-served order and no requester can starve.

Each requester port is a valid/ready pair. A requester holds `req_valid[i]` high until it sees `req_ready[i]` high in the same cycle, and it must not drop the request before then. At most one handshake completes per cycle. When several requests wait at once, the lowest index is accepted first. The others are held back by `req_ready` low and receive the next consecutive tickets in the cycles that follow, in index order.

Top module: `ticket_lock_arbiter`

## Requirements
- R1: After reset the serving count is 0, `busy` is 0, `queue_count` is 0, `release_err` is 0, and the first ticket handed out is 0.
- R2: `req_ready` has at most one bit set. That bit belongs to the lowest-indexed requester whose `req_valid` is high, and `req_ready` is all zero when no request is valid.
- R3: The ticket presented on `req_ticket` during a handshake equals the number of earlier handshakes since reset, modulo 2^TKT_W. Successive handshakes therefore get distinct, consecutive tickets.
- R4: A `release_pulse` while `busy` is high raises `now_serving` by exactly one on the next cycle. Without a release, `now_serving` holds its value.
- R5: `queue_count` equals (issued minus released) modulo 2^TKT_W, and `busy` is high exactly when that difference is nonzero.
- R6: A `release_pulse` while `busy` is low leaves `now_serving` unchanged. `release_err` is high in the following cycle, and only in cycles that directly follow such an ignored release.
- R7: Both counters wrap modulo 2^TKT_W (256 by default), and ownership is judged by equality after the wrap.
- R8: A handshake and a valid release in the same cycle both take effect. The ticket advances, `now_serving` advances, and `queue_count` is unchanged.
- R9: The lock passes in FIFO order. After each valid release, `now_serving` equals the ticket of the oldest requester that has not yet released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | N_REQ | Per-requester ticket request, held until accepted |
| req_ready | output | N_REQ | One-hot acceptance; the handshake completes when valid and ready are both high |
| req_ticket | output | TKT_W | Ticket given to the requester accepted this cycle |
| release_pulse | input | 1 | Owner gives the lock up |
| now_serving | output | TKT_W | Broadcast ticket of the current holder |
| busy | output | 1 | Tickets are outstanding |
| queue_count | output | TKT_W | Outstanding tickets: holder plus waiters |
| release_err | output | 1 | One-cycle flag for a release that came while the lock was idle |

## Verification
A ticket handshake and a release can land in the same cycle. When they do, each counter moves independently, and the queue count must come out unchanged. The bench provokes this by raising one request in the very cycle it pulses release against a held lock. It then judges the result by the scoreboard's ticket comparison and by `now_serving` and `queue_count` on the following cycle. Bursts in which several requesters assert together exercise priority order against strict back-pressure, and a long run of more than 256 acquire/release pairs crosses the wrap.

// File: rtl/tkl_pkg.sv
package tkl_pkg;
  localparam int unsigned TKL_TKT_W = 8;
  localparam int unsigned TKL_N_REQ = 4;
endpackage

// File: rtl/tkl_prio_pick.sv
module tkl_prio_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar gi = 0; gi < N; gi++) begin : g_chain
    assign gnt_o[gi]  = req_i[gi] & ~seen[gi];
    assign seen[gi+1] = seen[gi] | req_i[gi];
  end
  assign any_o = seen[N];
endmodule

// File: rtl/tkl_wrap_counter.sv
module tkl_wrap_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= '0;
    else if (inc_i) q_o <= q_o + W'(1);
  end
endmodule

// File: rtl/ticket_lock_arbiter.sv
module ticket_lock_arbiter #(
  parameter int unsigned N_REQ = tkl_pkg::TKL_N_REQ,
  parameter int unsigned TKT_W = tkl_pkg::TKL_TKT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req_valid,
  output logic [N_REQ-1:0] req_ready,
  output logic [TKT_W-1:0] req_ticket,
  input  logic             release_pulse,
  output logic [TKT_W-1:0] now_serving,
  output logic             busy,
  output logic [TKT_W-1:0] queue_count,
  output logic             release_err
);
  logic [N_REQ-1:0] pick;
  logic             take;
  logic             rel_ok;
  logic [TKT_W-1:0] issue_q;
  logic [TKT_W-1:0] serve_q;

  // R2: fixed priority, lowest index first
  tkl_prio_pick #(.N(N_REQ)) u_pick (
    .req_i(req_valid), .gnt_o(pick), .any_o(take)
  );

  // R3, R7: fetch-and-increment on the issue counter
  tkl_wrap_counter #(.W(TKT_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .inc_i(take), .q_o(issue_q)
  );

  // R4, R6: serving counter advances only on a valid release
  assign rel_ok = release_pulse & busy;
  tkl_wrap_counter #(.W(TKT_W)) u_serve (
    .clk(clk), .rst_n(rst_n), .inc_i(rel_ok), .q_o(serve_q)
  );

  assign req_ready   = pick;
  assign req_ticket  = issue_q;
  assign now_serving = serve_q;
  assign busy        = (issue_q != serve_q);
  assign queue_count = issue_q - serve_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) release_err <= 1'b0;
    else        release_err <= release_pulse & ~busy;
  end
endmodule

// File: rtl/tkl_checker.sv
module tkl_checker #(
  parameter int unsigned N_REQ = 4,
  parameter int unsigned TKT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_REQ-1:0] req_valid,
  input logic [N_REQ-1:0] req_ready,
  input logic [TKT_W-1:0] req_ticket,
  input logic             release_pulse,
  input logic [TKT_W-1:0] now_serving,
  input logic             busy,
  input logic [TKT_W-1:0] queue_count,
  input logic             release_err
);
  AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(req_ready)); // R2
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) (req_ready & ~req_valid) == '0); // R2
  AST_READY_WHEN_ANY: assert property (@(posedge clk) disable iff (!rst_n) (|req_valid) |-> (|req_ready)); // R2
  AST_TICKET_STEP: assert property (@(posedge clk) disable iff (!rst_n) (|req_ready) |=> req_ticket == $past(req_ticket) + TKT_W'(1)); // R3
  AST_TICKET_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(|req_ready) |=> $stable(req_ticket)); // R3
  AST_SERVE_STEP: assert property (@(posedge clk) disable iff (!rst_n) (release_pulse && busy) |=> now_serving == $past(now_serving) + TKT_W'(1)); // R4
  AST_SERVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !release_pulse |=> $stable(now_serving)); // R4
  AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (!rst_n) busy == (queue_count != '0)); // R5
  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (release_pulse && !busy) |=> release_err && $stable(now_serving)); // R6
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) (release_pulse == 1'b0 || busy) |=> !release_err); // R6
  AST_QUEUE_BALANCE: assert property (@(posedge clk) disable iff (!rst_n) ((|req_ready) && release_pulse && busy) |=> $stable(queue_count)); // R8
endmodule

bind ticket_lock_arbiter tkl_checker #(.N_REQ(N_REQ), .TKT_W(TKT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_ticket(req_ticket), .release_pulse(release_pulse), .now_serving(now_serving),
  .busy(busy), .queue_count(queue_count), .release_err(release_err)
);

// File: tb/tb_ticket_lock_arbiter.sv
module tb_ticket_lock_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int W = 8;
  localparam int MOD = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_valid = '0;
  logic [N-1:0] req_ready;
  logic [W-1:0] req_ticket;
  logic         release_pulse = 1'b0;
  logic [W-1:0] now_serving;
  logic         busy;
  logic [W-1:0] queue_count;
  logic         release_err;

  ticket_lock_arbiter #(.N_REQ(N), .TKT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ticket(req_ticket), .release_pulse(release_pulse), .now_serving(now_serving),
    .busy(busy), .queue_count(queue_count), .release_err(release_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int id; int tkt; } item_t;
  item_t sb_q[$];
  item_t holders[$];
  int checks = 0;
  int errors = 0;
  int exp_next = 0;
  int exp_serv = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pop expected grants as handshakes happen
  always @(negedge clk) begin
    if (rst_n && (|(req_valid & req_ready))) begin
      int gid;
      gid = -1;
      for (int i = 0; i < N; i++) if (req_ready[i]) gid = i;
      if (sb_q.size() == 0) chk(1'b0, "R2 unexpected grant", gid, -1);
      else begin
        item_t e;
        e = sb_q.pop_front();
        chk(gid == e.id, "R2 grant order", gid, e.id);
        chk(int'(req_ticket) == e.tkt, "R3 ticket value", req_ticket, e.tkt);
      end
    end
  end

  task automatic check_status(input string tag);
    int ec;
    ec = (exp_next - exp_serv) % MOD;
    chk(int'(now_serving) == exp_serv % MOD, {tag, " serving"}, now_serving, exp_serv % MOD);
    chk(int'(queue_count) == ec, {"R5 count ", tag}, queue_count, ec);
    chk(busy == (ec != 0), {"R5 busy ", tag}, busy, ec != 0);
  endtask

  // driver: push expectations, then hold requests until accepted
  task automatic issue(input logic [N-1:0] mask, input bit rel);
    logic [N-1:0] pend;
    logic [N-1:0] seen;
    bit busy_before;
    busy_before = (exp_next != exp_serv);
    for (int i = 0; i < N; i++) if (mask[i]) begin
      item_t e;
      e.id = i; e.tkt = exp_next % MOD;
      sb_q.push_back(e);
      holders.push_back(e);
      exp_next++;
    end
    if (rel && busy_before) begin
      void'(holders.pop_front());
      exp_serv++;
    end
    pend = mask;
    @(posedge clk); #1;
    req_valid = pend;
    release_pulse = rel;
    while (pend != '0) begin
      @(negedge clk);
      seen = req_ready & req_valid;
      @(posedge clk); #1;
      release_pulse = 1'b0;
      pend = pend & ~seen;
      req_valid = pend;
    end
    @(negedge clk);
  endtask

  task automatic do_release();
    bit busy_before;
    busy_before = (exp_next != exp_serv);
    @(posedge clk); #1;
    release_pulse = 1'b1;
    @(posedge clk); #1;
    release_pulse = 1'b0;
    if (busy_before) begin
      void'(holders.pop_front());
      exp_serv++;
    end
    @(negedge clk);
    chk(release_err == !busy_before, "R6 release_err", release_err, !busy_before);
    if (busy_before) begin
      chk(int'(now_serving) == exp_serv % MOD, "R4 serving step", now_serving, exp_serv % MOD);
      if (holders.size() > 0)
        chk(int'(now_serving) == holders[0].tkt, "R9 FIFO owner", now_serving, holders[0].tkt);
    end else begin
      chk(int'(now_serving) == exp_serv % MOD, "R6 serving unchanged", now_serving, exp_serv % MOD);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(now_serving == 0, "R1 serving", now_serving, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(queue_count == 0, "R1 count", queue_count, 0);
    chk(release_err == 0, "R1 err", release_err, 0);
    chk(req_ready == 0, "R2 idle ready", req_ready, 0);

    issue(4'b0001, 1'b0);               // R1 first ticket is 0
    check_status("R5 single");
    issue(4'b1010, 1'b0);               // R2 priority, R3 consecutive
    check_status("R5 pair");
    issue(4'b1111, 1'b0);
    check_status("R5 burst");
    while (exp_next != exp_serv) do_release();   // R4, R9
    check_status("R4 drained");

    do_release();                       // R6 idle release
    @(negedge clk);
    chk(release_err == 0, "R6 err single cycle", release_err, 0);
    check_status("R6 after");

    issue(4'b0010, 1'b0);
    issue(4'b0100, 1'b1);               // R8 handshake and release together
    check_status("R8 same cycle");
    chk(queue_count == 1, "R8 count held", queue_count, 1);
    do_release();

    for (int k = 0; k < 300; k++) begin // R7 wrap
      issue(N'(1) << (k % N), 1'b0);
      do_release();
    end
    check_status("R7 wrap");
    chk(int'(now_serving) == exp_next % MOD, "R7 wrapped serving", now_serving, exp_next % MOD);
    chk(sb_q.size() == 0, "R3 scoreboard empty", sb_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule